// File: doc/BRIEF.md
# Receive Frame Packer

The block takes received Ethernet frame bytes, one per clock from a byte-wide line-side input, and packs them into 64-bit beats. Each finished beat goes into a small internal buffer of eight beats. The buffer feeds a valid/ready packet-streaming output that carries start-of-packet, end-of-packet, a count of unused byte lanes and a 6-bit error field. The line side marks the final byte of each frame with `inLast`, and it cannot be stalled.

Two conditions are reported per frame, on the end-of-packet beat only. A frame shorter than 64 bytes sets the undersize bit. A frame that could not be written in full sets the overflow bit. Overflow happens when the downstream sink holds `outReady` low until the buffer fills. The frame is then cut short: a marker beat closes it, and the rest of its bytes are discarded.

Top module: `rx_frame_packer`

## Requirements
- R1: The first byte of a frame occupies `outData[63:56]`. Each following byte fills the next lower 8-bit lane, and a beat closes after eight bytes or at the frame's last byte. Lanes that are not filled in a closing beat read as zero.
- R2: `outSop` is high, together with `outValid`, on the first beat written for a frame, and low on every other beat.
- R3: `outEop` is high on the beat that holds a frame's last byte. On that beat `outEmpty` equals 7 minus the lane index of the last byte. On beats without end-of-packet, `outEmpty` is 0.
- R4: On the end-of-packet beat, `outError[2]` is 1 when the frame held fewer than 64 bytes and 0 when it held 64 or more.
- R5: `outError` is all zero on every beat that is not end-of-packet. Bits 0, 1, 3 and 4 are always zero.
- R6: While `outValid` is high and `outReady` is low, every output holds its value. A beat leaves the buffer only on a clock edge where `outValid` and `outReady` are both high.
- R7: The buffer holds eight beats. It counts as full when it held eight beats before the edge, even if a beat leaves on that same edge. No beat is written while it is full.
- R8: A beat that closes while the buffer is full is dropped, and the frame becomes truncated. At the first edge where the buffer holds fewer than eight beats, a marker beat is written. The marker has zero data, end-of-packet high, `outEmpty` 0 and `outError` equal to 6'b100000. Its `outSop` is high only if no earlier beat of that frame was written. Bytes of the truncated frame after the drop are discarded, up to and including its last byte.
- R9: Every byte that arrives while a marker is still waiting is discarded. If such a discarded byte is not flagged last, discarding continues up to and including the next byte flagged last.
- R10: During reset and right after it, `outValid` is low and all other outputs are zero. When `outValid` is low, all outputs are zero.
- R11: With an empty buffer, a beat appears on the outputs right after the edge that samples its closing byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A received byte is present this cycle |
| inByte | input | 8 | Received byte |
| inLast | input | 1 | This byte is the final byte of its frame |
| outReady | input | 1 | Downstream sink accepts a beat |
| outValid | output | 1 | A beat is presented |
| outData | output | 64 | Packed beat, first byte in the top lane |
| outSop | output | 1 | First beat of a frame |
| outEop | output | 1 | Final beat of a frame |
| outEmpty | output | 3 | Unused byte lanes in the end-of-packet beat |
| outError | output | 6 | Bit 2 undersize, bit 5 overflow; end-of-packet beat only |

## Verification
The assertions assume that `inLast` is only meaningful together with `inValid`. They also assume that the sink may lower `outReady` at any time and for as long as it likes, because that is the only way the buffer fills. The stimulus keeps `inLast` low whenever `inValid` is low. It includes idle gaps inside frames, and it holds ready low long enough to force truncation both mid-frame and on the very first beat of a frame. The per-cycle model expects that `inLast` appears exactly once per frame. Every generated frame obeys this, including the frames that arrive while a marker is still waiting.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  localparam int BeatBytes   = 8;
  localparam int LaneW       = $clog2(BeatBytes);
  localparam int DataW       = 8 * BeatBytes;
  localparam int ErrW        = 6;
  localparam int ErrUnderBit = 2;
  localparam int ErrOvfBit   = 5;

  // One buffered output beat.
  typedef struct packed {
    logic [DataW-1:0] data;
    logic             sop;
    logic             eop;
    logic [LaneW-1:0] empty;
    logic [ErrW-1:0]  err;
  } beat_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             take;        // merge inByte into the assembly word
    logic             close;       // the assembled beat is complete this cycle
    logic [LaneW-1:0] lane;        // target lane of inByte
    logic             pushBeat;    // write the assembled beat
    logic             pushMarker;  // write a truncation marker beat
    logic             sop;
    logic             eop;
    logic [LaneW-1:0] empty;
    logic [ErrW-1:0]  err;
  } strobe_t;
endpackage

// File: rtl/rxpk_ctrl.sv
module rxpk_ctrl
  import rxpk_pkg::*;
#(
  parameter int MinFrame = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inLast,
  input  logic    bufFull,
  output strobe_t stb
);
  localparam int CntW = $clog2(MinFrame + 1);
  localparam logic [LaneW-1:0] LastLane = LaneW'(BeatBytes - 1);

  logic [LaneW-1:0] lane;
  logic [CntW-1:0]  byteCnt;
  logic             wroteBeat;
  logic             markerPending;
  logic             markerSop;
  logic             discard;
  logic             dropping;

  always_comb begin
    dropping       = discard | markerPending;
    stb            = '0;
    stb.lane       = lane;
    stb.take       = inValid & ~dropping;
    stb.close      = stb.take & (inLast | (lane == LastLane));
    stb.pushBeat   = stb.close & ~bufFull;
    stb.pushMarker = markerPending & ~bufFull;
    if (markerPending) begin
      stb.sop            = markerSop;
      stb.eop            = 1'b1;
      stb.err[ErrOvfBit] = 1'b1;
    end else begin
      stb.sop = ~wroteBeat;
      stb.eop = inLast;
      if (inLast) begin
        stb.empty = LastLane - lane;
        if (byteCnt < CntW'(MinFrame - 1)) stb.err[ErrUnderBit] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lane          <= '0;
      byteCnt       <= '0;
      wroteBeat     <= 1'b0;
      markerPending <= 1'b0;
      markerSop     <= 1'b0;
      discard       <= 1'b0;
    end else begin
      if (stb.pushMarker) markerPending <= 1'b0;
      if (stb.take) begin
        if (stb.close && bufFull) begin
          markerPending <= 1'b1;
          markerSop     <= ~wroteBeat;
          wroteBeat     <= 1'b0;
          lane          <= '0;
          byteCnt       <= '0;
          discard       <= ~inLast;
        end else begin
          lane      <= stb.close ? '0 : lane + 1'b1;
          byteCnt   <= inLast ? '0 :
                       (byteCnt == CntW'(MinFrame)) ? byteCnt : byteCnt + 1'b1;
          if (inLast)            wroteBeat <= 1'b0;
          else if (stb.pushBeat) wroteBeat <= 1'b1;
        end
      end else if (inValid) begin
        discard <= ~inLast;
      end
    end
  end

  // A marker and a data beat never compete for the write port.
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.pushBeat && stb.pushMarker)); // R8

  // After a truncating drop, the following byte is never merged.
  AST_DROP_AFTER_OVF: assert property (@(posedge clk) disable iff (!rstN)
    (stb.close && bufFull) |=> !(inValid && stb.take)); // R8

  // While a marker waits, no byte enters the assembly word.
  AST_PENDING_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    markerPending |-> !stb.take); // R9
endmodule

// File: rtl/rxpk_datapath.sv
module rxpk_datapath
  import rxpk_pkg::*;
#(
  parameter int Depth = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [7:0] inByte,
  input  logic       outReady,
  output logic       bufFull,
  output logic       outValid,
  output beat_t      outBeat
);
  localparam int PtrW = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int CntW = $clog2(Depth + 1);

  logic [DataW-1:0] asmWord;
  logic [DataW-1:0] merged;
  beat_t            mem [Depth];
  beat_t            wrBeat;
  logic [PtrW-1:0]  wrPtr;
  logic [PtrW-1:0]  rdPtr;
  logic [CntW-1:0]  count;
  logic             push;
  logic             pop;

  for (genvar g = 0; g < BeatBytes; g++) begin : gLane
    localparam int Hi = DataW - 1 - 8 * g;
    assign merged[Hi -: 8] = (stb.take && stb.lane == LaneW'(g)) ? inByte : asmWord[Hi -: 8];
  end

  assign bufFull  = (count == CntW'(Depth));
  assign outValid = (count != '0);
  assign push     = stb.pushBeat | stb.pushMarker;
  assign pop      = outValid & outReady;

  always_comb begin
    wrBeat.data  = stb.pushMarker ? '0 : merged;
    wrBeat.sop   = stb.sop;
    wrBeat.eop   = stb.eop;
    wrBeat.empty = stb.empty;
    wrBeat.err   = stb.err;
    outBeat      = outValid ? mem[rdPtr] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      asmWord <= '0;
    end else if (stb.take) begin
      asmWord <= stb.close ? '0 : merged;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == PtrW'(Depth - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == PtrW'(Depth - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CntW'(push) - CntW'(pop);
    end
  end

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count < CntW'(Depth))); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outBeat))); // R6

  AST_ERR_ONLY_EOP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outBeat.eop) |-> (outBeat.err == '0 && outBeat.empty == '0)); // R5

  AST_SPARE_ERR_BITS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outBeat.err[4:3] == 2'b00 && outBeat.err[1:0] == 2'b00)); // R5
endmodule

// File: rtl/rx_frame_packer.sv
module rx_frame_packer
  import rxpk_pkg::*;
#(
  parameter int MinFrame = 64,
  parameter int Depth    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [7:0]       inByte,
  input  logic             inLast,
  input  logic             outReady,
  output logic             outValid,
  output logic [DataW-1:0] outData,
  output logic             outSop,
  output logic             outEop,
  output logic [LaneW-1:0] outEmpty,
  output logic [ErrW-1:0]  outError
);
  strobe_t stb;
  logic    bufFull;
  beat_t   outBeat;

  rxpk_ctrl #(.MinFrame(MinFrame)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .bufFull (bufFull),
    .stb     (stb)
  );

  rxpk_datapath #(.Depth(Depth)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inByte   (inByte),
    .outReady (outReady),
    .bufFull  (bufFull),
    .outValid (outValid),
    .outBeat  (outBeat)
  );

  assign outData  = outBeat.data;
  assign outSop   = outBeat.sop;
  assign outEop   = outBeat.eop;
  assign outEmpty = outBeat.empty;
  assign outError = outBeat.err;
endmodule

// File: tb/test_rx_frame_packer.sv
module test_rx_frame_packer;
  typedef struct packed {
    logic [63:0] d;
    logic        sop;
    logic        eop;
    logic [2:0]  emp;
    logic [5:0]  err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, inLast, outReady;
  logic [7:0]  inByte;
  logic        outValid, outSop, outEop;
  logic [63:0] outData;
  logic [2:0]  outEmpty;
  logic [5:0]  outError;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rx_frame_packer i_rx_frame_packer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte), .inLast(inLast),
    .outReady(outReady), .outValid(outValid), .outData(outData), .outSop(outSop),
    .outEop(outEop), .outEmpty(outEmpty), .outError(outError)
  );

  // Behavioural reference state
  exp_t        q[$];
  int          mLane, mCnt;
  bit          mWrote, mPend, mPendSop, mDiscard;
  logic [63:0] mAsm;
  int          rdyMode;
  logic [15:0] lfsr = 16'hACE1;
  exp_t        prevOut;
  bit          prevValid;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic modelStep(input bit v, input logic [7:0] b, input bit l, input bit rdy);
    bit full, dropping, pend0, psop0;
    full = (q.size() >= 8);
    dropping = mDiscard || mPend;
    pend0 = mPend;
    psop0 = mPendSop;
    if (q.size() > 0 && rdy) void'(q.pop_front());
    if (pend0 && !full) begin
      q.push_back('{d:64'd0, sop:psop0, eop:1'b1, emp:3'd0, err:6'b100000});
      mPend = 0;
    end
    if (v && !dropping) begin
      logic [63:0] m;
      m = mAsm | ({56'd0, b} << (56 - 8 * mLane));
      if (mLane == 7 || l) begin
        if (!full) begin
          q.push_back('{d:m, sop:!mWrote, eop:l, emp:(l ? 3'(7 - mLane) : 3'd0),
                        err:((l && mCnt + 1 < 64) ? 6'b000100 : 6'b0)});
          mWrote = !l;
          mCnt = l ? 0 : mCnt + 1;
        end else begin
          mPend = 1; mPendSop = !mWrote; mWrote = 0; mCnt = 0; mDiscard = !l;
        end
        mLane = 0; mAsm = '0;
      end else begin
        mAsm = m; mLane++; mCnt++;
      end
    end else if (v) begin
      mDiscard = !l;
    end
  endtask

  task automatic compareOut();
    exp_t e, a;
    bit ok;
    e = (q.size() > 0) ? q[0] : '0;
    a = '{d:outData, sop:outSop, eop:outEop, emp:outEmpty, err:outError};
    ok = (outValid == (q.size() > 0)) && (a == e);
    compared++;
    if (!ok) begin
      mismatched++;
      if (outValid != (q.size() > 0))
        $display("FAIL R7 valid actual=%0b expected=%0b t=%0t", outValid, q.size() > 0, $time);
      if (a.d != e.d)     $display("FAIL R1 data actual=%h expected=%h t=%0t", a.d, e.d, $time);
      if (a.sop != e.sop) $display("FAIL R2 sop actual=%0b expected=%0b t=%0t", a.sop, e.sop, $time);
      if (a.eop != e.eop || a.emp != e.emp)
        $display("FAIL R3 eop/empty actual=%0b/%0d expected=%0b/%0d t=%0t", a.eop, a.emp, e.eop, e.emp, $time);
      if (a.err != e.err)
        $display("FAIL R4/R5/R8 error actual=%b expected=%b t=%0t", a.err, e.err, $time);
    end
  endtask

  task automatic cycle(input bit v, input logic [7:0] b, input bit l);
    bit rdy, hold;
    case (rdyMode)
      0: rdy = 1;
      1: rdy = 0;
      default: rdy = lfsr[0] | lfsr[5];
    endcase
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    inValid = v; inByte = b; inLast = l; outReady = rdy;
    hold = prevValid && !rdy;
    modelStep(v, b, l, rdy);
    @(negedge clk);
    compareOut();
    if (hold) begin
      // R6: outputs held while valid and not ready
      check(outValid && outData == prevOut.d && outSop == prevOut.sop && outEop == prevOut.eop
            && outEmpty == prevOut.emp && outError == prevOut.err,
            "R6", "hold", outData, prevOut.d);
    end
    prevValid = outValid;
    prevOut = '{d:outData, sop:outSop, eop:outEop, emp:outEmpty, err:outError};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle(0, 8'h00, 0);
  endtask

  task automatic sendFrame(input int len, input int seed, input int gapEvery);
    for (int i = 0; i < len; i++) begin
      if (gapEvery > 0 && (i % gapEvery) == gapEvery - 1) cycle(0, 8'h00, 0);
      cycle(1, 8'(seed * 7 + i + 1), i == len - 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 0; inValid = 0; inByte = 0; inLast = 0; outReady = 0;
    mLane = 0; mCnt = 0; mWrote = 0; mPend = 0; mPendSop = 0; mDiscard = 0; mAsm = '0;
    rdyMode = 0; prevValid = 0; prevOut = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!outValid && outData == 0 && !outSop && !outEop && outEmpty == 0 && outError == 0,
          "R10", "reset", {63'd0, outValid}, 64'd0);
    rstN = 1;
    idle(2);

    // R11: single byte frame appears right after its edge; R2/R3 sop+eop, empty 7
    cycle(1, 8'h5A, 1);
    check(outValid && outData == 64'h5A00_0000_0000_0000 && outEmpty == 3'd7,
          "R11", "latency", outData, 64'h5A00_0000_0000_0000);
    idle(3);

    sendFrame(64, 1, 0);   // R4 boundary: exactly 64, not undersized
    idle(4);
    sendFrame(63, 2, 0);   // R4: undersized, empty 1
    idle(4);
    sendFrame(16, 3, 0);   // R3: exact multiple, empty 0
    idle(3);
    sendFrame(9, 4, 0);    // R1: lane fill across beats
    idle(3);

    rdyMode = 2;           // R6: random backpressure with gapped input
    sendFrame(100, 5, 5);
    sendFrame(70, 6, 0);
    sendFrame(12, 7, 3);
    idle(40);

    // R8: mid-frame truncation, then R9: a frame arriving while marker waits
    rdyMode = 0; idle(10);
    rdyMode = 1;
    sendFrame(100, 8, 0);
    sendFrame(10, 9, 0);
    rdyMode = 0; idle(20);

    // R8: truncation on the final beat of a frame
    rdyMode = 1;
    sendFrame(56, 10, 0);
    sendFrame(12, 11, 0);
    sendFrame(5, 12, 0);
    rdyMode = 0; idle(20);

    // R8: truncation on the first beat, marker carries sop; R7 full with no early credit
    rdyMode = 1;
    for (int k = 0; k < 8; k++) sendFrame(1, 20 + k, 0);
    sendFrame(20, 30, 0);
    rdyMode = 2;
    sendFrame(30, 31, 4);
    idle(40);
    rdyMode = 0;
    sendFrame(64, 32, 0);
    idle(20);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule